// File: doc/BRIEF.md
# UTOPIA Transmit Multi-PHY Slave Port

This block is the PHY end of a shared UTOPIA Level 2/3 transmit cell bus. It watches a 5-bit address bus that the ATM-layer master drives. When the master polls the block's own address, the block answers on the cell-available line whether it can take another whole cell. When the master selects the block for writing, the block takes in 16-bit words. Each word is aligned to the start-of-cell marker. A cell is 54 bytes, which is 27 words, W0 to W26. The block stores whole cells in a small buffer built on block RAM.

Address 0x1F is the NULL address and belongs to no PHY. In interleaved polling the master places NULL between poll addresses. The block answers its own address only when NULL came just before it. With Level 3 mode and the back-to-back enable both set, the block answers its address on every clock. The transmit path reads complete cells from a word-wide ready/valid stream. Each cell on that stream carries start and end markers.

Top module: `utx_slave_port`

## Requirements
- R1: While reset is high and on the first cycle after it, tx_clav_oe, tx_clav, runt_err and out_valid are all 0.
- R2: The poll answer is registered. If tx_addr equals PHY_ADDR and the polling rule allows an answer, then one clock later tx_clav_oe is 1. In that case tx_clav is 1 exactly when the stored cells plus any cell still being received number fewer than CELL_DEPTH. For any other address, 0x1F included, tx_clav_oe and tx_clav are both 0 one clock later.
- R3: Back-to-back mode is active only when cfg_level3 = 1 and cfg_b2b_en = 1. In any other setting the own address gets an answer only if the address sampled on the clock before was 0x1F. The cycle just after reset counts as preceded by 0x1F.
- R4: When back-to-back mode is active, every clock that samples the own address is answered, whatever address came before.
- R5: Selection is decided on clocks where tx_enb_n = 1. The own address selects the port. Any other address except 0x1F deselects it. The address 0x1F leaves the selection as it was.
- R6: A word is captured only on a clock where tx_enb_n = 0 and the port is selected. tx_soc = 1 marks W0. A cell is complete after W26, and the word count then wraps to 0. A word with tx_soc = 0 outside any cell is discarded.
- R7: If tx_soc = 1 arrives while a cell is partly received, the partial cell is dropped. runt_err is 1 for exactly the following clock. The new word starts a fresh cell as W0.
- R8: Complete cells leave on out_data in arrival order, 27 words each. out_sop = 1 marks W0 and out_eop = 1 marks W26. While out_valid = 1 and out_ready = 0, the output word and its markers hold. A word is taken on a clock where out_valid = 1 and out_ready = 1.
- R9: When CELL_DEPTH cells are stored, a poll answer gives tx_clav = 0. A cell started while the buffer is full is discarded in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_level3 | input | 1 | Level 3 bus mode |
| cfg_b2b_en | input | 1 | Back-to-back polling enable (control bit 5) |
| tx_addr | input | 5 | Shared poll/select address, 0x1F = NULL |
| tx_enb_n | input | 1 | Active-low write enable |
| tx_soc | input | 1 | Start-of-cell, marks W0 |
| tx_data | input | 16 | Cell word |
| tx_clav | output | 1 | Cell-available answer |
| tx_clav_oe | output | 1 | High while this port drives tx_clav |
| runt_err | output | 1 | One-clock pulse when a partial cell is dropped |
| out_ready | input | 1 | Transmit path accepts a word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output cell word |
| out_sop | output | 1 | Output word is W0 |
| out_eop | output | 1 | Output word is W26 |

## Verification
A wrong selection flag or polling-history bit shows up one clock later at the ports. It appears as a tx_clav_oe pulse that should not be there, or one that is missing, or as cell words captured for another PHY. A word counter or write slot that has drifted does not show until the cell is read out. Then the stream has misplaced start/end markers, words in the wrong order, or extra or missing cells. A wrong count of stored cells shows first as a wrong tx_clav value on the next poll of the own address.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] NULL_ADDR = 5'h1F;

  typedef enum logic {
    POLL_INTERLEAVED = 1'b0,
    POLL_B2B         = 1'b1
  } poll_mode_e;
endpackage

// File: rtl/utx_poll_ctrl.sv
module utx_poll_ctrl
  import utx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_level3,
  input  logic              cfg_b2b_en,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic              tx_enb_n,
  input  logic              room,
  output logic              tx_clav,
  output logic              tx_clav_oe,
  output logic              selected
);
  poll_mode_e mode;
  logic       prev_null;
  logic       own_hit;
  logic       answer;

  assign mode    = (cfg_level3 && cfg_b2b_en) ? POLL_B2B : POLL_INTERLEAVED;
  assign own_hit = (tx_addr == PHY_ADDR);
  assign answer  = own_hit && ((mode == POLL_B2B) || prev_null);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_null  <= 1'b1;
      tx_clav_oe <= 1'b0;
      tx_clav    <= 1'b0;
      selected   <= 1'b0;
    end else begin
      prev_null  <= (tx_addr == NULL_ADDR);
      tx_clav_oe <= answer;
      tx_clav    <= answer && room;
      if (tx_enb_n) begin
        if (own_hit)
          selected <= 1'b1;
        else if (tx_addr != NULL_ADDR)
          selected <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/utx_cell_asm.sv
module utx_cell_asm #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CELL_WORDS = 27,
  parameter int unsigned CELL_DEPTH = 4,
  localparam int unsigned IDX_W  = $clog2(CELL_WORDS),
  localparam int unsigned SLOT_W = (CELL_DEPTH > 1) ? $clog2(CELL_DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(CELL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              soc,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  cells_used,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic              in_cell,
  output logic              runt_err
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_WORDS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CELL_DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(CELL_DEPTH);

  logic [IDX_W-1:0]  idx;
  logic [SLOT_W-1:0] slot;
  logic              slot_free;
  logic              at_last;

  assign slot_free = (cells_used < FULL_CNT);
  assign at_last   = (idx == LAST_IDX);
  assign wr_en     = capture && (soc ? slot_free : in_cell);
  assign wr_slot   = slot;
  assign wr_idx    = soc ? '0 : idx;
  assign wr_data   = data;
  assign commit    = capture && !soc && in_cell && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      slot     <= '0;
      in_cell  <= 1'b0;
      runt_err <= 1'b0;
    end else begin
      runt_err <= 1'b0;
      if (capture) begin
        if (soc) begin
          runt_err <= in_cell;
          in_cell  <= slot_free;
          idx      <= slot_free ? IDX_W'(1) : '0;
        end else if (in_cell) begin
          if (at_last) begin
            in_cell <= 1'b0;
            idx     <= '0;
            slot    <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/utx_cell_buf.sv
module utx_cell_buf #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CELL_WORDS = 27,
  parameter int unsigned CELL_DEPTH = 4,
  localparam int unsigned IDX_W  = $clog2(CELL_WORDS),
  localparam int unsigned SLOT_W = (CELL_DEPTH > 1) ? $clog2(CELL_DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(CELL_DEPTH + 1),
  localparam int unsigned MEM_WORDS = CELL_WORDS * CELL_DEPTH,
  localparam int unsigned MADDR_W   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [CNT_W-1:0]  cells_used
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_WORDS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CELL_DEPTH - 1);

  logic [DATA_W-1:0]  mem [MEM_WORDS];
  logic [MADDR_W-1:0] waddr;
  logic [MADDR_W-1:0] raddr;
  logic [SLOT_W-1:0]  rd_slot;
  logic [IDX_W-1:0]   rd_idx;
  logic               issue;
  logic               release_slot;

  assign waddr = MADDR_W'(wr_slot) * MADDR_W'(CELL_WORDS) + MADDR_W'(wr_idx);
  assign raddr = MADDR_W'(rd_slot) * MADDR_W'(CELL_WORDS) + MADDR_W'(rd_idx);
  assign issue = (cells_used != '0) && (!out_valid || out_ready);
  assign release_slot = issue && (rd_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[waddr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (issue)
      out_data <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      rd_slot    <= '0;
      rd_idx     <= '0;
      cells_used <= '0;
    end else begin
      cells_used <= cells_used + CNT_W'(commit) - CNT_W'(release_slot);
      if (issue) begin
        out_valid <= 1'b1;
        out_sop   <= (rd_idx == '0);
        out_eop   <= (rd_idx == LAST_IDX);
        if (rd_idx == LAST_IDX) begin
          rd_idx  <= '0;
          rd_slot <= (rd_slot == LAST_SLOT) ? '0 : rd_slot + 1'b1;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/utx_slave_port.sv
module utx_slave_port
  import utx_pkg::*;
#(
  parameter logic [4:0]  PHY_ADDR   = 5'd2,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CELL_WORDS = 27,
  parameter int unsigned CELL_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_level3,
  input  logic              cfg_b2b_en,
  input  logic [4:0]        tx_addr,
  input  logic              tx_enb_n,
  input  logic              tx_soc,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_clav,
  output logic              tx_clav_oe,
  output logic              runt_err,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  // PHY_ADDR must never be the NULL address 0x1F.
  localparam int unsigned IDX_W  = $clog2(CELL_WORDS);
  localparam int unsigned SLOT_W = (CELL_DEPTH > 1) ? $clog2(CELL_DEPTH) : 1;
  localparam int unsigned CNT_W  = $clog2(CELL_DEPTH + 1);

  logic              selected;
  logic              room;
  logic              in_cell;
  logic [CNT_W-1:0]  cells_used;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              commit;

  // A cell still arriving already holds its slot.
  assign room = ({1'b0, cells_used} + (CNT_W+1)'(in_cell)) < (CNT_W+1)'(CELL_DEPTH);

  utx_poll_ctrl #(.PHY_ADDR(PHY_ADDR)) i_poll (
    .clk(clk), .rst(rst), .cfg_level3(cfg_level3), .cfg_b2b_en(cfg_b2b_en),
    .tx_addr(tx_addr), .tx_enb_n(tx_enb_n), .room(room),
    .tx_clav(tx_clav), .tx_clav_oe(tx_clav_oe), .selected(selected)
  );

  utx_cell_asm #(.DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .CELL_DEPTH(CELL_DEPTH)) i_asm (
    .clk(clk), .rst(rst), .capture(!tx_enb_n && selected), .soc(tx_soc),
    .data(tx_data), .cells_used(cells_used), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_idx(wr_idx), .wr_data(wr_data), .commit(commit), .in_cell(in_cell),
    .runt_err(runt_err)
  );

  utx_cell_buf #(.DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .CELL_DEPTH(CELL_DEPTH)) i_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
    .wr_data(wr_data), .commit(commit), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .cells_used(cells_used)
  );
endmodule

// File: rtl/utx_slave_port_chk.sv
module utx_slave_port_chk #(
  parameter logic [4:0]  PHY_ADDR   = 5'd2,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CELL_DEPTH = 4,
  parameter int unsigned CNT_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_level3,
  input logic              cfg_b2b_en,
  input logic [4:0]        tx_addr,
  input logic              tx_enb_n,
  input logic              tx_clav,
  input logic              tx_clav_oe,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_eop,
  input logic              selected,
  input logic [CNT_W-1:0]  cells_used
);
  a_r2_quiet_clav: assert property (@(posedge clk) disable iff (rst)
    !tx_clav_oe |-> !tx_clav);
  a_r2_foreign_addr: assert property (@(posedge clk) disable iff (rst)
    (tx_addr != PHY_ADDR) |=> !tx_clav_oe);
  a_r3_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (!(cfg_level3 && cfg_b2b_en) && tx_addr == PHY_ADDR) ##1
    (!(cfg_level3 && cfg_b2b_en) && tx_addr == PHY_ADDR) |=> !tx_clav_oe);
  a_r4_b2b_answer: assert property (@(posedge clk) disable iff (rst)
    (cfg_level3 && cfg_b2b_en && tx_addr == PHY_ADDR) |=> tx_clav_oe);
  a_r5_select: assert property (@(posedge clk) disable iff (rst)
    (tx_enb_n && tx_addr == PHY_ADDR) |=> selected);
  a_r5_deselect: assert property (@(posedge clk) disable iff (rst)
    (tx_enb_n && tx_addr != PHY_ADDR && tx_addr != 5'h1F) |=> !selected);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_eop));
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cells_used <= CNT_W'(CELL_DEPTH));
  a_r9_full_clav: assert property (@(posedge clk) disable iff (rst)
    (cells_used == CNT_W'(CELL_DEPTH)) |=> !tx_clav);
endmodule

bind utx_slave_port utx_slave_port_chk #(
  .PHY_ADDR(PHY_ADDR), .DATA_W(DATA_W), .CELL_DEPTH(CELL_DEPTH), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst(rst), .cfg_level3(cfg_level3), .cfg_b2b_en(cfg_b2b_en),
  .tx_addr(tx_addr), .tx_enb_n(tx_enb_n), .tx_clav(tx_clav),
  .tx_clav_oe(tx_clav_oe), .out_ready(out_ready), .out_valid(out_valid),
  .out_data(out_data), .out_eop(out_eop), .selected(selected),
  .cells_used(cells_used)
);

// File: tb/test_utx_slave_port.sv
module test_utx_slave_port;
  localparam logic [4:0] PHY = 5'd2;
  localparam logic [4:0] NUL = 5'h1F;
  localparam int WORDS = 27;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_level3 = 1'b0, cfg_b2b_en = 1'b0;
  logic [4:0] tx_addr = NUL;
  logic tx_enb_n = 1'b1, tx_soc = 1'b0;
  logic [15:0] tx_data = '0;
  logic tx_clav, tx_clav_oe, runt_err;
  logic out_ready = 1'b0;
  logic out_valid, out_sop, out_eop;
  logic [15:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  bit m_sel = 0, m_prev_null = 1, m_in_cell = 0, eop_pending = 0;
  int m_used = 0;
  logic [15:0] m_cur[$];
  logic [17:0] exp_q[$];

  always #4 clk = ~clk;

  utx_slave_port #(.PHY_ADDR(PHY)) i_utx_slave_port (
    .clk(clk), .rst(rst), .cfg_level3(cfg_level3), .cfg_b2b_en(cfg_b2b_en),
    .tx_addr(tx_addr), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc), .tx_data(tx_data),
    .tx_clav(tx_clav), .tx_clav_oe(tx_clav_oe), .runt_err(runt_err),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expect_answer(input logic [4:0] a);
    return (a == PHY) && ((cfg_level3 && cfg_b2b_en) || m_prev_null);
  endfunction

  // One bus clock: drive, let the edge pass, update the model, check outputs.
  task automatic step(input string tag, input logic [4:0] a, input logic en_n,
                      input logic soc, input logic [15:0] d);
    bit ans, room, exp_runt;
    tx_addr = a; tx_enb_n = en_n; tx_soc = soc; tx_data = d;
    @(posedge clk);
    ans = expect_answer(a);
    room = (m_used + int'(m_in_cell)) < DEPTH;
    exp_runt = 0;
    if (!en_n && m_sel) begin
      if (soc) begin
        exp_runt = m_in_cell;
        m_cur.delete();
        if (m_used < DEPTH) begin
          m_in_cell = 1;
          m_cur.push_back(d);
        end else m_in_cell = 0;
      end else if (m_in_cell) begin
        m_cur.push_back(d);
        if (m_cur.size() == WORDS) begin
          for (int i = 0; i < WORDS; i++)
            exp_q.push_back({(i == 0), (i == WORDS-1), m_cur[i]});
          m_cur.delete();
          m_used++;
          m_in_cell = 0;
        end
      end
    end
    if (en_n) begin
      if (a == PHY) m_sel = 1;
      else if (a != NUL) m_sel = 0;
    end
    m_prev_null = (a == NUL);
    #1;
    chk({tag, " clav_oe"}, tx_clav_oe, ans);
    chk({tag, " clav"}, tx_clav, ans && room);
    chk("R7 runt_err", runt_err, exp_runt);
  endtask

  task automatic send_cell(input string tag, input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++)
      step(tag, NUL, 1'b0, (i == 0), base + 16'(i));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("R2", NUL, 1'b1, 1'b0, 16'h0);
  endtask

  // Output stream checker, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      if (out_eop && !eop_pending) begin
        m_used--;
        eop_pending = 1;
      end
      if (out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R8 unexpected word", {14'd0, out_sop, out_eop, out_data}, 32'hFFFFFFFF);
        end else begin
          chk("R8 stream word", {14'd0, out_sop, out_eop, out_data}, {14'd0, exp_q[0]});
          void'(exp_q.pop_front());
        end
        if (out_eop) eop_pending = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 clav_oe in reset", tx_clav_oe, 0);
    chk("R1 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 clav_oe", tx_clav_oe, 0);
    chk("R1 clav", tx_clav, 0);
    chk("R1 runt", runt_err, 0);
    chk("R1 out_valid", out_valid, 0);

    // R3: interleaved polling
    step("R3", PHY, 1'b1, 1'b0, 0);   // preceded by reset -> answered
    step("R3", PHY, 1'b1, 1'b0, 0);   // repeat without NULL -> silent
    step("R2", 5'd5, 1'b1, 1'b0, 0);  // foreign
    step("R3", PHY, 1'b1, 1'b0, 0);   // after foreign -> silent
    step("R2", NUL, 1'b1, 1'b0, 0);
    step("R3", PHY, 1'b1, 1'b0, 0);   // after NULL -> answered
    // R4: enable bit alone keeps interleaved behaviour
    cfg_b2b_en = 1'b1;
    step("R4", 5'd7, 1'b1, 1'b0, 0);
    step("R4", PHY, 1'b1, 1'b0, 0);
    cfg_level3 = 1'b1;
    step("R4", 5'd7, 1'b1, 1'b0, 0);
    step("R4", PHY, 1'b1, 1'b0, 0);
    step("R4", PHY, 1'b1, 1'b0, 0);
    step("R4", 5'd0, 1'b1, 1'b0, 0);
    step("R4", PHY, 1'b1, 1'b0, 0);
    cfg_level3 = 1'b0; cfg_b2b_en = 1'b0;

    // R6: stray words before start-of-cell are dropped, then a cell
    step("R5", PHY, 1'b1, 1'b0, 0);
    for (int i = 0; i < 3; i++) step("R6", NUL, 1'b0, 1'b0, 16'hDEAD);
    send_cell("R6", WORDS, 16'h1000);
    // R5: deselected by another PHY; NULL keeps selection
    step("R5", 5'd9, 1'b1, 1'b0, 0);
    send_cell("R5", WORDS, 16'h2000);
    step("R5", PHY, 1'b1, 1'b0, 0);
    step("R5", NUL, 1'b1, 1'b0, 0);
    send_cell("R5", WORDS, 16'h3000);
    // R7: runt then full cell
    send_cell("R7", 10, 16'h4000);
    send_cell("R7", WORDS, 16'h5000);
    out_ready = 1'b1;
    idle(4 * WORDS);
    chk("R8 drained", exp_q.size(), 0);

    // R9: fill with output stalled
    out_ready = 1'b0;
    for (int c = 0; c < DEPTH; c++) send_cell("R9", WORDS, 16'h6000 + 16'(c * 64));
    step("R2", NUL, 1'b1, 1'b0, 0);
    step("R9", PHY, 1'b1, 1'b0, 0);   // full -> clav 0
    chk("R9 clav when full", tx_clav, 0);
    send_cell("R9", WORDS, 16'h7000); // dropped
    out_ready = 1'b1;
    idle((DEPTH + 1) * WORDS);
    step("R9", PHY, 1'b1, 1'b0, 0);
    chk("R9 clav after drain", tx_clav, 1);
    chk("R9 drained", exp_q.size(), 0);

    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [4:0] a;
      if (i % 500 == 0) begin
        cfg_level3 = 1'($urandom);
        cfg_b2b_en = 1'($urandom);
      end
      r = int'($urandom % 8);
      a = (r < 3) ? PHY : (r < 6) ? NUL : 5'(1 + ($urandom % 8));
      out_ready = ($urandom % 4) != 0;
      step("R2", a, ($urandom % 5) == 0, ($urandom % 28) == 0, 16'($urandom));
    end
    out_ready = 1'b1;
    idle((DEPTH + 1) * WORDS);
    chk("R8 final drain", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule